// File: doc/BRIEF.md
# Halved-Table Distributed-Arithmetic FIR Filter

This block is a clocked ten-tap finite impulse response filter for six-bit signed samples. Its tap weights are fixed when the design is elaborated. Each accepted sample enters a history register. The product sum is formed without multipliers, one bit position of the samples at a time. The even-numbered taps and the odd-numbered taps each address their own small lookup table with five history bits.

Each sample bit is read as a signed digit: a one counts as +1 and a zero counts as -1. Under this reading, each table satisfies T(~a) = -T(a). Only the half whose top address bit is set is therefore built. A bitwise-invert step, plus a carry-in correction, supplies the other half.

Twelve table words and one correction word go into a five-level carry-save tree. A parallel-prefix carry-lookahead adder then forms the final sum. The result is registered at full precision. A valid strobe travels with the data, so the upstream clocked logic sees a fixed-depth pipeline.

Top module: `fir_da`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` is driven to 0, `out_y` to 0 and every history entry to zero.
- R2: For the k-th accepted sample, `out_y` equals the exact sum over i = 0..9 of h_i * x(k-i). Samples x are 6-bit two's complement values. Weight h_i is the signed 8-bit field `TAPS[8i+7:8i]`. `out_y` is a 19-bit two's complement value with no rounding.
- R3: A sample accepted at rising edge t (`in_valid` high) raises `out_valid` for exactly one cycle. The raise happens at edge t+3, and `out_y` updates at the same edge. Samples on consecutive cycles give consecutive valid cycles.
- R4: A rising edge with `in_valid` low does not shift the history, whatever `in_x` carries. The next result is formed only from the accepted samples.
- R5: `out_y` holds its value through every cycle in which `out_valid` is low.
- R6: Extreme inputs give exact results. These include ten consecutive samples of -32, ten of +31, and alternating -32/+31, with weights of -128 and +127 among the taps.
- R7: After reset, history positions not yet filled count as zero samples. The first result therefore equals h_0 times the first sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept `in_x` at this edge |
| in_x | input | 6 | Signed input sample |
| out_valid | output | 1 | One-cycle strobe: `out_y` carries a new result |
| out_y | output | 19 | Signed filter output, full precision |

## Verification
A result is due at the third rising edge after the edge that accepts its sample. The bench drives inputs at a falling edge, so that sample's result becomes visible at the fourth falling edge after the drive. The bench keeps a four-deep record of expected strobes and values, advanced once per falling edge. It compares `out_valid` and `out_y` against the oldest entry in every cycle after reset. When that entry holds no strobe, the bench instead expects the last result to be held. Gaps in `in_valid` carry junk on `in_x`, so a history shift on an idle edge shows up in a later result.

// File: rtl/fir_da.sv
module fir_da #(
  parameter int NTAPS = 10,
  parameter int W = 6,
  parameter int CW = 8,
  parameter logic [NTAPS*CW-1:0] TAPS = {8'd5, 8'hF6, 8'd21, 8'd40, 8'hC4,
                                         8'd64, 8'hEC, 8'd12, 8'hF9, 8'd2},
  localparam int HALF = NTAPS / 2,
  localparam int AW = HALF - 1,
  localparam int DEPTH = 1 << AW,
  localparam int TW = CW + $clog2(HALF) + 1,
  localparam int ACCW = CW + W + $clog2(NTAPS) + 2,
  localparam int YW = ACCW - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [W-1:0]         in_x,
  output logic                 out_valid,
  output logic signed [YW-1:0] out_y
);

  localparam int NOPS = 2 * W + 1;
  localparam int LOG = $clog2(ACCW);

  function automatic int tap(int i);
    return int'($signed(TAPS[i*CW +: CW]));
  endfunction

  function automatic int rom_val(int e, int idx);
    int s = 0;
    for (int k = 0; k < HALF; k++) begin
      if (k == HALF - 1 || ((idx >> k) & 1) == 1) s += tap(2 * k + e);
      else s -= tap(2 * k + e);
    end
    return s;
  endfunction

  function automatic int tap_sum();
    int s = 0;
    for (int i = 0; i < NTAPS; i++) s += tap(i);
    return s;
  endfunction

  function automatic int nxt(int n);
    return 2 * (n / 3) + n % 3;
  endfunction

  function automatic int cnt_at(int l);
    int n = NOPS;
    for (int i = 0; i < l; i++) n = nxt(n);
    return n;
  endfunction

  function automatic int nlev();
    int n = NOPS;
    int l = 0;
    for (int i = 0; i < 64; i++) begin
      if (n > 2) begin
        n = nxt(n);
        l++;
      end
    end
    return l;
  endfunction

  localparam int NLEV = nlev();
  localparam int HS = tap_sum();

  logic [W-1:0]    hist [NTAPS];
  logic            vs, v1, v2;
  logic [TW-1:0]   rom [2][DEPTH];
  logic [TW-1:0]   p_d [2][W];
  logic [TW-1:0]   p_q [2][W];
  logic [W-1:0]    negv [2];
  logic [ACCW-1:0] corr_d, corr_q;
  logic [ACCW-1:0] tree [NLEV+1][NOPS];
  logic [ACCW-1:0] s_q, c_q;
  logic [ACCW-1:0] gk [LOG+1];
  logic [ACCW-1:0] pk [LOG];
  logic [ACCW-1:0] sum_full;

  for (genvar e = 0; e < 2; e++) begin : g_rom
    for (genvar i = 0; i < DEPTH; i++) begin : g_w
      assign rom[e][i] = TW'(rom_val(e, i));
    end
  end

  for (genvar e = 0; e < 2; e++) begin : g_il
    for (genvar j = 0; j < W; j++) begin : g_s
      logic [HALF-1:0] a;
      logic [AW-1:0]   idx;
      logic            neg;
      for (genvar k = 0; k < HALF; k++) begin : g_a
        assign a[k] = hist[2*k+e][j] ^ (j == W - 1);
      end
      assign neg = ~a[HALF-1];
      assign idx = a[AW-1:0] ^ {AW{neg}};
      assign p_d[e][j] = rom[e][idx] ^ {TW{neg}};
      assign negv[e][j] = neg;
    end
  end

  assign corr_d = ACCW'(negv[0]) + ACCW'(negv[1]) - ACCW'(HS);

  for (genvar e = 0; e < 2; e++) begin : g_op
    for (genvar j = 0; j < W; j++) begin : g_b
      assign tree[0][2*j+e] = {{(ACCW-TW){p_q[e][j][TW-1]}}, p_q[e][j]} << j;
    end
  end
  assign tree[0][NOPS-1] = corr_q;

  for (genvar l = 0; l < NLEV; l++) begin : g_lv
    localparam int N = cnt_at(l);
    localparam int G = N / 3;
    localparam int M = nxt(N);
    for (genvar g = 0; g < G; g++) begin : g_csa
      logic [ACCW-1:0] x0, x1, x2;
      assign x0 = tree[l][3*g];
      assign x1 = tree[l][3*g+1];
      assign x2 = tree[l][3*g+2];
      assign tree[l+1][2*g]   = x0 ^ x1 ^ x2;
      assign tree[l+1][2*g+1] = ((x0 & x1) | (x0 & x2) | (x1 & x2)) << 1;
    end
    for (genvar r = 0; r < N % 3; r++) begin : g_pass
      assign tree[l+1][2*G+r] = tree[l][3*G+r];
    end
    for (genvar u = M; u < NOPS; u++) begin : g_zero
      assign tree[l+1][u] = '0;
    end
  end

  assign gk[0] = s_q & c_q;
  assign pk[0] = s_q ^ c_q;
  for (genvar s = 0; s < LOG; s++) begin : g_pfx
    localparam int D = 1 << s;
    for (genvar i = 0; i < ACCW; i++) begin : g_bit
      if (i >= D) begin : g_mrg
        assign gk[s+1][i] = gk[s][i] | (pk[s][i] & gk[s][i-D]);
        if (s + 1 < LOG) begin : g_p
          assign pk[s+1][i] = pk[s][i] & pk[s][i-D];
        end
      end else begin : g_cpy
        assign gk[s+1][i] = gk[s][i];
        if (s + 1 < LOG) begin : g_p
          assign pk[s+1][i] = pk[s][i];
        end
      end
    end
  end
  assign sum_full = pk[0] ^ {gk[LOG][ACCW-2:0], 1'b0};

  wire unused_bits = ^{sum_full[0], gk[LOG][ACCW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) hist[i] <= '0;
      for (int e = 0; e < 2; e++)
        for (int j = 0; j < W; j++) p_q[e][j] <= '0;
      corr_q    <= '0;
      s_q       <= '0;
      c_q       <= '0;
      vs        <= 1'b0;
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      if (in_valid) begin
        hist[0] <= in_x;
        for (int i = 1; i < NTAPS; i++) hist[i] <= hist[i-1];
      end
      vs <= in_valid;
      for (int e = 0; e < 2; e++)
        for (int j = 0; j < W; j++) p_q[e][j] <= p_d[e][j];
      corr_q    <= corr_d;
      v1        <= vs;
      s_q       <= tree[NLEV][0];
      c_q       <= tree[NLEV][1];
      v2        <= v1;
      out_valid <= v2;
      if (v2) out_y <= sum_full[ACCW-1:1];
    end
  end

endmodule

// File: rtl/fir_da_chk.sv
module fir_da_chk #(
  parameter int W = 6,
  parameter int YW = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [YW-1:0] out_y,
  input logic [W-1:0]  newest,
  input logic          stage_v,
  input logic          sum_lsb
);

  // R3
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##4 out_valid);

  // R3
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##4 !out_valid);

  // R5
  hold_output_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_y));

  // R4
  idle_no_shift_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(newest));

  // R2
  even_double_sum_chk: assert property (@(posedge clk) disable iff (rst)
    stage_v |-> !sum_lsb);

endmodule

bind fir_da fir_da_chk #(.W(W), .YW(YW)) u_chk (
  .clk(clk),
  .rst(rst),
  .in_valid(in_valid),
  .out_valid(out_valid),
  .out_y(out_y),
  .newest(hist[0]),
  .stage_v(v2),
  .sum_lsb(sum_full[0])
);

// File: tb/tb_fir_da.sv
module tb_fir_da;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 10;
  localparam int YW = 19;
  localparam logic [79:0] BT = {8'd64, 8'hFF, 8'd19, 8'hB3, 8'h58,
                                8'd0, 8'hFD, 8'h2D, 8'h80, 8'h7F};
  localparam int H [NT] = '{127, -128, 45, -3, 0, 88, -77, 19, -1, 64};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [5:0] in_x = '0;
  logic out_valid;
  logic signed [YW-1:0] out_y;

  fir_da #(.TAPS(BT)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_y(out_y)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int bh [NT];
  bit sv [5];
  int sy [5];
  int held = 0;
  string tag = "R2";

  task automatic chk(string t, integer act, integer exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  function automatic int model();
    int s = 0;
    for (int i = 0; i < NT; i++) s += H[i] * bh[i];
    return s;
  endfunction

  task automatic step(bit v, logic [5:0] x);
    @(negedge clk);
    for (int k = 4; k > 0; k--) begin
      sv[k] = sv[k-1];
      sy[k] = sy[k-1];
    end
    chk("R3", integer'(out_valid), integer'(sv[4]));
    if (sv[4]) begin
      held = sy[4];
      chk(tag, integer'(out_y), held);
    end else begin
      chk("R5", integer'(out_y), held);
    end
    in_valid = v;
    in_x = x;
    sv[0] = v;
    if (v) begin
      for (int i = NT - 1; i > 0; i--) bh[i] = bh[i-1];
      bh[0] = int'($signed(x));
      sy[0] = model();
    end else begin
      sy[0] = 0;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) step(1'b0, 6'(i * 11));
  endtask

  initial begin
    for (int i = 0; i < NT; i++) bh[i] = 0;
    for (int k = 0; k < 5; k++) begin
      sv[k] = 1'b0;
      sy[k] = 0;
    end
    void'($urandom(32'h5EED1234));
    repeat (3) begin
      @(negedge clk);
      chk("R1", integer'(out_valid), 0);
      chk("R1", integer'(out_y), 0);
    end
    rst = 1'b0;

    // R7: first result uses zero history
    tag = "R7";
    step(1'b1, 6'd31);
    step(1'b0, 6'h2A);
    step(1'b1, 6'h20);
    drain();

    // R4: idle edges carry junk on in_x
    tag = "R4";
    step(1'b1, 6'd7);
    step(1'b0, 6'h3F);
    step(1'b0, 6'h15);
    step(1'b1, 6'h39);
    step(1'b0, 6'h01);
    step(1'b1, 6'd12);
    drain();

    // R6: extreme patterns
    tag = "R6";
    for (int i = 0; i < NT; i++) step(1'b1, 6'h20);
    for (int i = 0; i < NT; i++) step(1'b1, 6'h1F);
    for (int i = 0; i < 2 * NT; i++) step(1'b1, (i % 2 == 0) ? 6'h20 : 6'h1F);
    drain();

    // R3 and R2: back-to-back, then random mix
    tag = "R3";
    for (int i = 0; i < 30; i++) step(1'b1, 6'($urandom));
    tag = "R2";
    for (int i = 0; i < 2000; i++)
      step($urandom_range(0, 9) < 7, 6'($urandom));
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule